// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

A general-purpose timer built on a free-running up-counter (16 bits by default). The counter advances either on ticks from a programmable clock divider (divide by 1 to 128) or, in pulse-count mode, on synchronized edges of an external count pin. Two channels share the counter. Each channel is set up either to latch the counter on an edge of its capture pin, or to drive its output pin when the counter reaches a programmed value.

A separate PWM output can be enabled. In that mode the counter restarts from zero after it reaches a period value, and the output is high while the count is below a duty value. Events set sticky flags. Software clears a flag by writing 1 to its bit, and the interrupt line is the OR of all flags.

Software reaches the block through a flat register port. A write takes effect on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. Addresses: 0 control, 1 counter, 2 period, 3 duty, 4 flags, 8 channel 0 setup, 9 channel 0 value, 10 channel 1 setup, 11 channel 1 value. Any other address reads as zero.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads zero and `cmp_out`, `pwm_out` and `irq` are low.
- R2: The control register (address 0) has these fields: bit 0 run, bit 1 PWM mode, bit 2 pulse-count mode, bit 3 count-on-falling-edge, bits 10:4 divider value p. While run is set and pulse-count mode is clear, the counter advances once every p+1 clocks, counted from the write that set run. While run is clear, the counter does not move.
- R3: When the counter advances from all ones, it becomes 0 and sets flag bit 0.
- R4: Writing the flag register (address 4) clears each bit written as 1 and leaves each bit written as 0. A new event in the same cycle wins over the clear.
- R5: A channel whose setup bit 0 is 0 is in capture mode. On the edge of its capture pin selected by setup bit 1 (0 rising, 1 falling), it latches the counter into its value register and sets its event flag (bit 1 for channel 0, bit 2 for channel 1). The value is visible three clocks after the pin changes, because of a two-stage synchronizer. The opposite edge is ignored.
- R6: A capture that happens while the channel's event flag is still set also sets the channel's overrun flag (bit 3 for channel 0, bit 4 for channel 1).
- R7: A channel whose setup bit 0 is 1 is in compare mode. When the counter steps onto the channel value, the channel's output pin changes according to setup bits 3:2, on the same edge, and the event flag is set. The codes are 00 hold, 01 drive high, 10 drive low, 11 invert.
- R8: In pulse-count mode, the counter advances once per synchronized edge of `cnt_in` (rising, or falling when bit 3 is set), and the divider is bypassed.
- R9: In PWM mode, the counter goes from the period value (address 2) to 0. `pwm_out` is high exactly while the counter is below the duty value (address 3).
- R10: Writing address 1 loads the counter with the written value on that edge.
- R11: `irq` is high whenever any flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cap_in | input | 2 | Capture pins, one per channel (asynchronous) |
| cnt_in | input | 1 | External count pin (asynchronous) |
| cmp_out | output | 2 | Compare output pins, one per channel |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
A wrong divider or next-count state shows on the counter register within one divided period, and the bench reads the counter after an exact number of clocks. A bad compare or capture path shows on `cmp_out` or a channel value register within three clocks of the causing event. A flag that never sets or never clears shows at once on `irq` and in the flag register. An off-by-one in the PWM restart shows within one period, because the counter and `pwm_out` are sampled on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Compare action codes, held in channel setup bits 3:2
   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_SET  = 2'b01,
      ACT_CLR  = 2'b10,
      ACT_TGL  = 2'b11
   } cmp_act_e;

   // Register addresses
   localparam int A_CTRL    = 0;
   localparam int A_COUNT   = 1;
   localparam int A_PERIOD  = 2;
   localparam int A_DUTY    = 3;
   localparam int A_FLAGS   = 4;
   localparam int A_CH_BASE = 8;   // setup at base+2i, value at base+2i+1

   // Control register bit positions
   localparam int CB_RUN     = 0;
   localparam int CB_PWM     = 1;
   localparam int CB_EXT     = 2;
   localparam int CB_EXTFALL = 3;
   localparam int CB_PSC     = 4;

   // Channel setup width
   localparam int CH_CFG_W = 4;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);

   initial begin : chk_stages
      assert (STAGES >= 2) else $fatal(1, "tmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], din};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~last_q;
   assign fall = ~sh_q[STAGES-1] & last_q;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PSC_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             ext_mode,
   input  logic             ext_evt,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);

   logic [PSC_W-1:0] pcnt_q;
   logic             wrap;

   assign wrap = (pcnt_q == psc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (restart || !run || ext_mode || wrap)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + 1'b1;
   end

   assign tick = run & (ext_mode ? ext_evt : wrap);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CH_CFG_W-1:0] cfg_wdata,
   input  logic                val_we,
   input  logic [CNT_W-1:0]    val_wdata,
   input  logic                adv,
   input  logic [CNT_W-1:0]    cnt_q,
   input  logic [CNT_W-1:0]    cnt_nxt,
   input  logic                cap_rise,
   input  logic                cap_fall,
   input  logic                clr_ev,
   input  logic                clr_ovr,
   output logic [CH_CFG_W-1:0] cfg_q,
   output logic [CNT_W-1:0]    val_q,
   output logic                ev_q,
   output logic                ovr_q,
   output logic                pin_q
);

   logic     cmp_mode;
   logic     cap_evt;
   logic     match;
   cmp_act_e act;

   assign cmp_mode = cfg_q[0];
   assign act      = cmp_act_e'(cfg_q[3:2]);
   assign cap_evt  = ~cmp_mode & (cfg_q[1] ? cap_fall : cap_rise);
   assign match    = cmp_mode & adv & (cnt_nxt == val_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         val_q <= '0;
         ev_q  <= 1'b0;
         ovr_q <= 1'b0;
         pin_q <= 1'b0;
      end else begin
         if (cfg_we)
            cfg_q <= cfg_wdata;

         if (cap_evt)
            val_q <= cnt_q;
         else if (val_we)
            val_q <= val_wdata;

         if (cap_evt || match)
            ev_q <= 1'b1;
         else if (clr_ev)
            ev_q <= 1'b0;

         if (cap_evt && ev_q)
            ovr_q <= 1'b1;
         else if (clr_ovr)
            ovr_q <= 1'b0;

         if (match) begin
            case (act)
               ACT_SET:  pin_q <= 1'b1;
               ACT_CLR:  pin_q <= 1'b0;
               ACT_TGL:  pin_q <= ~pin_q;
               default:  pin_q <= pin_q;
            endcase
         end
      end
   end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 7,
   parameter int NCH         = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic [NCH-1:0]    cap_in,
   input  logic              cnt_in,
   output logic [NCH-1:0]    cmp_out,
   output logic              pwm_out,
   output logic              irq
);

   localparam int CTRL_W = CB_PSC + PSC_W;
   localparam int FLAG_W = 1 + 2 * NCH;
   localparam int N_ADDR = A_CH_BASE + 2 * NCH;

   initial begin : chk_params
      assert (CTRL_W <= CNT_W)       else $fatal(1, "tmr_unit: control fields exceed data width");
      assert (FLAG_W <= CNT_W)       else $fatal(1, "tmr_unit: flags exceed data width");
      assert (N_ADDR <= 2 ** ADDR_W) else $fatal(1, "tmr_unit: address space too small");
      assert (NCH >= 1)              else $fatal(1, "tmr_unit: need at least one channel");
   end

   // ---------------- control and shared registers ----------------
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q, cnt_nxt, period_q, duty_q;
   logic              ovf_q;

   logic              run, pwm_mode, ext_mode, ext_fall;
   logic [PSC_W-1:0]  psc;

   assign run      = ctrl_q[CB_RUN];
   assign pwm_mode = ctrl_q[CB_PWM];
   assign ext_mode = ctrl_q[CB_EXT];
   assign ext_fall = ctrl_q[CB_EXTFALL];
   assign psc      = ctrl_q[CB_PSC +: PSC_W];

   logic ctrl_we, cnt_we, per_we, duty_we, flags_we;
   assign ctrl_we  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
   assign cnt_we   = reg_we && (reg_addr == ADDR_W'(A_COUNT));
   assign per_we   = reg_we && (reg_addr == ADDR_W'(A_PERIOD));
   assign duty_we  = reg_we && (reg_addr == ADDR_W'(A_DUTY));
   assign flags_we = reg_we && (reg_addr == ADDR_W'(A_FLAGS));

   // ---------------- tick source ----------------
   logic ext_rise, ext_fall_evt, ext_evt, tick, adv;

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cnt_in),
      .rise (ext_rise),
      .fall (ext_fall_evt)
   );

   assign ext_evt = ext_fall ? ext_fall_evt : ext_rise;

   tmr_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (ctrl_we | cnt_we),
      .ext_mode(ext_mode),
      .ext_evt (ext_evt),
      .psc     (psc),
      .tick    (tick)
   );

   assign adv = tick & ~cnt_we;

   // ---------------- counter ----------------
   always_comb begin
      if (pwm_mode && (cnt_q == period_q))
         cnt_nxt = '0;
      else
         cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cnt_q    <= '0;
         period_q <= '0;
         duty_q   <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_q   <= reg_wdata[CTRL_W-1:0];
         if (per_we)  period_q <= reg_wdata;
         if (duty_we) duty_q   <= reg_wdata;

         if (cnt_we)
            cnt_q <= reg_wdata;
         else if (tick)
            cnt_q <= cnt_nxt;

         if (tick && (cnt_q == '1))
            ovf_q <= 1'b1;
         else if (flags_we && reg_wdata[0])
            ovf_q <= 1'b0;
      end
   end

   // ---------------- channels ----------------
   logic [CH_CFG_W-1:0] ch_cfg [NCH];
   logic [CNT_W-1:0]    ch_val [NCH];
   logic [NCH-1:0]      ch_ev, ch_ovr;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic c_rise, c_fall, c_cfg_we, c_val_we;

      assign c_cfg_we = reg_we && (reg_addr == ADDR_W'(A_CH_BASE + 2 * i));
      assign c_val_we = reg_we && (reg_addr == ADDR_W'(A_CH_BASE + 2 * i + 1));

      tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (cap_in[i]),
         .rise (c_rise),
         .fall (c_fall)
      );

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (c_cfg_we),
         .cfg_wdata(reg_wdata[CH_CFG_W-1:0]),
         .val_we   (c_val_we),
         .val_wdata(reg_wdata),
         .adv      (adv),
         .cnt_q    (cnt_q),
         .cnt_nxt  (cnt_nxt),
         .cap_rise (c_rise),
         .cap_fall (c_fall),
         .clr_ev   (flags_we & reg_wdata[1 + i]),
         .clr_ovr  (flags_we & reg_wdata[1 + NCH + i]),
         .cfg_q    (ch_cfg[i]),
         .val_q    (ch_val[i]),
         .ev_q     (ch_ev[i]),
         .ovr_q    (ch_ovr[i]),
         .pin_q    (cmp_out[i])
      );
   end

   // ---------------- outputs ----------------
   logic [FLAG_W-1:0] flags;
   assign flags   = {ch_ovr, ch_ev, ovf_q};
   assign irq     = |flags;
   assign pwm_out = pwm_mode & (cnt_q < duty_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL):   reg_rdata = CNT_W'(ctrl_q);
         ADDR_W'(A_COUNT):  reg_rdata = cnt_q;
         ADDR_W'(A_PERIOD): reg_rdata = period_q;
         ADDR_W'(A_DUTY):   reg_rdata = duty_q;
         ADDR_W'(A_FLAGS):  reg_rdata = CNT_W'(flags);
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (reg_addr == ADDR_W'(A_CH_BASE + 2 * i))
                  reg_rdata = CNT_W'(ch_cfg[i]);
               if (reg_addr == ADDR_W'(A_CH_BASE + 2 * i + 1))
                  reg_rdata = ch_val[i];
            end
         end
      endcase
   end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             cnt_we,
   input logic             ctrl_we,
   input logic             flags_we,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] period_q,
   input logic             ovf_q,
   input logic             run,
   input logic             pwm_mode,
   input logic             ext_mode,
   input logic [PSC_W-1:0] psc
);

   assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_we) |=> $stable(cnt_q));

   assert_divider_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ext_mode && psc != '0 && tick && !ctrl_we && !cnt_we) |=> !tick);

   assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we && cnt_q == '1) |=> (ovf_q && cnt_q == '0));

   assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_we && wdata[0] && !(tick && cnt_q == '1)) |=> !ovf_q);

   assert_pwm_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && tick && !cnt_we && cnt_q == period_q) |=> cnt_q == '0);

   assert_count_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt_q == $past(wdata));

endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .cnt_we  (cnt_we),
   .ctrl_we (ctrl_we),
   .flags_we(flags_we),
   .wdata   (reg_wdata),
   .cnt_q   (cnt_q),
   .period_q(period_q),
   .ovf_q   (ovf_q),
   .run     (run),
   .pwm_mode(pwm_mode),
   .ext_mode(ext_mode),
   .psc     (psc)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [1:0]  cap_in = '0;
   logic        cnt_in = 1'b0;
   logic [1:0]  cmp_out;
   logic        pwm_out;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   tmr_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
      .cnt_in(cnt_in), .cmp_out(cmp_out), .pwm_out(pwm_out), .irq(irq)
   );

   localparam logic [3:0] CTRL = 0, COUNT = 1, PERIOD = 2, DUTY = 3, FLAGS = 4;
   localparam logic [3:0] CH0C = 8, CH0V = 9, CH1C = 10, CH1V = 11;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic waitn(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), d);
         chk("R1 register after reset", 32'(d), 32'h0);
      end
      chk("R1 cmp_out", 32'(cmp_out), 0);
      chk("R1 pwm_out", 32'(pwm_out), 0);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_prescale();
      logic [15:0] d, d2;
      wr(COUNT, 16'h0);
      wr(CTRL, 16'h0031);          // run, divide by 4
      waitn(40);
      rd(COUNT, d);
      chk("R2 divide by 4", 32'(d), 32'd10);
      wr(CTRL, 16'h0000);
      rd(COUNT, d);
      waitn(20);
      rd(COUNT, d2);
      chk("R2 stopped counter holds", 32'(d2), 32'(d));
      wr(COUNT, 16'h0);
      wr(CTRL, 16'h0001);          // divide by 1
      waitn(10);
      rd(COUNT, d);
      chk("R2 divide by 1", 32'(d), 32'd10);
      wr(CTRL, 16'h0000);
      wr(COUNT, 16'h0ABC);
      rd(COUNT, d);
      chk("R10 counter load", 32'(d), 32'h0ABC);
   endtask

   task automatic t_overflow();
      logic [15:0] d;
      wr(COUNT, 16'hFFFD);
      wr(CTRL, 16'h0001);
      waitn(2);
      rd(COUNT, d);
      chk("R3 counter at all ones", 32'(d), 32'hFFFF);
      rd(FLAGS, d);
      chk("R3 no flag before wrap", 32'(d), 32'h0);
      waitn(1);
      rd(COUNT, d);
      chk("R3 wrapped to zero", 32'(d), 32'h0);
      rd(FLAGS, d);
      chk("R3 overflow flag", 32'(d), 32'h1);
      chk("R11 irq on flag", 32'(irq), 1);
      wr(CTRL, 16'h0000);
      wr(FLAGS, 16'h0000);
      rd(FLAGS, d);
      chk("R4 writing zero keeps flag", 32'(d), 32'h1);
      wr(FLAGS, 16'h0001);
      rd(FLAGS, d);
      chk("R4 writing one clears flag", 32'(d), 32'h0);
      chk("R11 irq low after clear", 32'(irq), 0);
   endtask

   task automatic t_capture();
      logic [15:0] d;
      wr(CTRL, 16'h0000);
      wr(CH0C, 16'h0000);          // capture, rising
      wr(FLAGS, 16'h001F);
      wr(COUNT, 16'h1234);
      cap_in[0] = 1'b1;
      waitn(4);
      rd(CH0V, d);
      chk("R5 rising capture value", 32'(d), 32'h1234);
      rd(FLAGS, d);
      chk("R5 capture flag", 32'(d), 32'h2);
      wr(FLAGS, 16'h0002);
      wr(COUNT, 16'h2222);
      cap_in[0] = 1'b0;
      waitn(4);
      rd(CH0V, d);
      chk("R5 falling edge ignored value", 32'(d), 32'h1234);
      rd(FLAGS, d);
      chk("R5 falling edge ignored flag", 32'(d), 32'h0);
      cap_in[0] = 1'b1;
      waitn(4);
      rd(CH0V, d);
      chk("R5 second capture", 32'(d), 32'h2222);
      wr(COUNT, 16'h3333);
      cap_in[0] = 1'b0;
      waitn(4);
      cap_in[0] = 1'b1;
      waitn(4);
      rd(CH0V, d);
      chk("R6 capture while flag set", 32'(d), 32'h3333);
      rd(FLAGS, d);
      chk("R6 overrun flag", 32'(d), 32'h000A);
      wr(CH1C, 16'h0002);          // capture, falling
      wr(FLAGS, 16'h001F);
      wr(COUNT, 16'h4444);
      cap_in[1] = 1'b1;
      waitn(4);
      rd(FLAGS, d);
      chk("R5 ch1 rising ignored", 32'(d), 32'h0);
      cap_in[1] = 1'b0;
      waitn(4);
      rd(CH1V, d);
      chk("R5 ch1 falling capture", 32'(d), 32'h4444);
      rd(FLAGS, d);
      chk("R5 ch1 flag", 32'(d), 32'h4);
      wr(FLAGS, 16'h001F);
   endtask

   task automatic cmp_run(input logic [15:0] cfg);
      wr(CTRL, 16'h0000);
      wr(CH0C, cfg);
      wr(FLAGS, 16'h001F);
      wr(COUNT, 16'h000C);
      wr(CTRL, 16'h0001);
   endtask

   task automatic t_compare();
      logic [15:0] d;
      wr(CH0V, 16'h0010);
      cmp_run(16'h0005);           // compare, set
      waitn(3);
      chk("R7 pin before match", 32'(cmp_out[0]), 0);
      waitn(1);
      chk("R7 set on match", 32'(cmp_out[0]), 1);
      rd(FLAGS, d);
      chk("R7 compare flag", 32'(d), 32'h2);
      cmp_run(16'h0009);           // clear
      waitn(4);
      chk("R7 clear on match", 32'(cmp_out[0]), 0);
      cmp_run(16'h000D);           // invert
      waitn(4);
      chk("R7 invert on match", 32'(cmp_out[0]), 1);
      cmp_run(16'h0001);           // hold
      waitn(4);
      chk("R7 hold on match", 32'(cmp_out[0]), 1);
      rd(FLAGS, d);
      chk("R7 hold still flags", 32'(d), 32'h2);
      wr(CTRL, 16'h0000);
      wr(FLAGS, 16'h001F);
   endtask

   task automatic t_pulse();
      logic [15:0] d;
      wr(COUNT, 16'h0);
      wr(CTRL, 16'h0075);          // run, pulse mode, divider 7 bypassed
      for (int i = 0; i < 5; i++) begin
         cnt_in = 1'b1; waitn(3);
         cnt_in = 1'b0; waitn(3);
      end
      waitn(4);
      rd(COUNT, d);
      chk("R8 rising pulse count", 32'(d), 32'd5);
      wr(CTRL, 16'h007D);          // falling edges
      wr(COUNT, 16'h0);
      for (int i = 0; i < 3; i++) begin
         cnt_in = 1'b1; waitn(3);
         cnt_in = 1'b0; waitn(3);
      end
      waitn(4);
      rd(COUNT, d);
      chk("R8 falling pulse count", 32'(d), 32'd3);
      wr(CTRL, 16'h0000);
   endtask

   task automatic t_pwm();
      logic [15:0] d;
      wr(PERIOD, 16'd4);
      wr(DUTY, 16'd2);
      wr(COUNT, 16'h0);
      wr(CTRL, 16'h0003);          // run, PWM, divide by 1
      for (int k = 0; k < 10; k++) begin
         rd(COUNT, d);
         chk("R9 PWM counter sequence", 32'(d), 32'(k % 5));
         chk("R9 PWM output level", 32'(pwm_out), ((k % 5) < 2) ? 32'd1 : 32'd0);
         @(negedge clk);
      end
      wr(CTRL, 16'h0000);
      chk("R9 PWM off when mode clear", 32'(pwm_out), 0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      waitn(3);
      rst_n = 1'b1;
      waitn(2);
      t_reset();
      t_prescale();
      t_overflow();
      t_capture();
      t_compare();
      t_pulse();
      t_pwm();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule